// File: doc/BRIEF.md
# Flag-carrying add/subtract unit

This block is the 32-bit add/subtract slice of a small load/store processor. A single status bit, called T, is used both as the carry or borrow input and as the carry, borrow or signed-overflow result. The unit receives a 16-bit instruction word, the destination/source operand Rn and the source operand Rm, the current T value and a start strobe. It decodes the instruction word and computes one of five operations: add with carry, add with overflow detection, subtract with borrow, subtract with overflow detection, and negate with borrow.

The new Rn value, the new T value and a register write-enable are registered. They appear together with a one-cycle done pulse on the clock edge after the start strobe. The surrounding pipeline writes the result back to its register file, using the register indices that it extracts from the same instruction word. An instruction word that selects none of the five operations still completes with done, but the write-enable stays low and T is passed through unchanged. A generate-time parameter selects how the arithmetic is built. One form is a single shared carry-chain adder with operand inversion. The other is a set of separate two-step datapaths for each operation.

Top module: `flagalu_unit`

## Requirements
- R1: The operation is selected only by instruction bits 15:12 and bits 3:0. Bits 11:8 hold the destination index and bits 7:4 hold the source index. Those middle eight bits never change the result, the new T or the write-enable.
- R2: Pattern 4'h3 in bits 15:12 with 4'hE in bits 3:0 gives Rn+Rm+T. The new T is 1 when either Rn+Rm or the addition of T carries out of bit 31.
- R3: Pattern 4'h3 / 4'hF gives Rn+Rm with no carry input. The new T is 1 only when Rn and Rm share a sign bit and the result's sign bit differs from it.
- R4: Pattern 4'h3 / 4'hA gives Rn-Rm-T. The new T is 1 when either Rn-Rm or the subtraction of T borrows.
- R5: Pattern 4'h3 / 4'hB gives Rn-Rm. The new T is 1 only when Rn and Rm have different sign bits and the result's sign bit differs from Rn's.
- R6: Pattern 4'h6 / 4'hA gives 0-Rm-T. The new T is 1 when 0-Rm is nonzero or when subtracting T borrows; this equals (Rm != 0) OR T.
- R7: The result, new T, write-enable and done appear on the clock edge after a cycle with start high. Done is high for exactly that one cycle, and write-enable is high together with done for any of the five patterns.
- R8: A started word that matches none of the five patterns gives done=1 and write-enable=0. The new T equals the T input and the result equals the Rn input.
- R9: In a cycle after one without start, done and write-enable are 0, and the result and T outputs keep their previous values.
- R10: While reset is active, the result, T, write-enable and done outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; operands and instruction are sampled when high |
| insn_i | input | 16 | Instruction word |
| rn_i | input | DATA_W | Destination/source operand Rn |
| rm_i | input | DATA_W | Source operand Rm |
| t_i | input | 1 | Current T status bit |
| rn_o | output | DATA_W | New Rn value |
| t_o | output | 1 | New T status bit |
| wr_en_o | output | 1 | Rn write-enable |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with DATA_W=32 and the default shared-adder variant (SHARED_ADDER=1). With these values, the single carry chain and its operand-inversion paths must match bench functions that use the separate two-step carry and borrow definitions. The 32-bit width brings the sign-boundary corners within reach: 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, combined with T in both states. Random instruction words with random middle bits, mixed with unmatched patterns, exercise the decode isolation and the pass-through of T.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;
   localparam int INSN_W = 16;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_ADDC = 3'd1,
      OP_ADDV = 3'd2,
      OP_SUBC = 3'd3,
      OP_SUBV = 3'd4,
      OP_NEGC = 3'd5
   } op_e;

   localparam logic [3:0] GRP_DUAL  = 4'h3;
   localparam logic [3:0] GRP_UNARY = 4'h6;
   localparam logic [3:0] SEL_ADDC  = 4'hE;
   localparam logic [3:0] SEL_ADDV  = 4'hF;
   localparam logic [3:0] SEL_SUBC  = 4'hA;
   localparam logic [3:0] SEL_SUBV  = 4'hB;
   localparam logic [3:0] SEL_NEGC  = 4'hA;
endpackage

// File: rtl/flagalu_decode.sv
module flagalu_decode
   import flagalu_pkg::*;
(
   input  logic [INSN_W-1:0] insn_i,
   output op_e               op_o
);
   logic [3:0] grp, sel;
   assign grp = insn_i[15:12];
   assign sel = insn_i[3:0];

   always_comb begin
      op_o = OP_NONE;
      if (grp == GRP_DUAL) begin
         case (sel)
            SEL_ADDC: op_o = OP_ADDC;
            SEL_ADDV: op_o = OP_ADDV;
            SEL_SUBC: op_o = OP_SUBC;
            SEL_SUBV: op_o = OP_SUBV;
            default:  op_o = OP_NONE;
         endcase
      end else if (grp == GRP_UNARY && sel == SEL_NEGC) begin
         op_o = OP_NEGC;
      end
   end
endmodule

// File: rtl/flagalu_core.sv
module flagalu_core
   import flagalu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  op_e               op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              t_i,
   output logic [DATA_W-1:0] res_o,
   output logic              t_o,
   output logic              valid_o
);
   localparam int MSB = DATA_W - 1;
   localparam int EXT = DATA_W + 1;

   assign valid_o = (op_i != OP_NONE);

   if (SHARED_ADDER) begin : g_shared
      logic [DATA_W-1:0] opa, opb;
      logic              cin;
      logic [EXT-1:0]    sum;
      logic              cout, ovf;

      always_comb begin
         opa = a_i;
         opb = b_i;
         cin = 1'b0;
         case (op_i)
            OP_ADDC: cin = t_i;
            OP_SUBC: begin opb = ~b_i; cin = ~t_i; end
            OP_SUBV: begin opb = ~b_i; cin = 1'b1; end
            OP_NEGC: begin opa = '0; opb = ~b_i; cin = ~t_i; end
            default: ;
         endcase
      end

      assign sum  = {1'b0, opa} + {1'b0, opb} + EXT'(cin);
      assign cout = sum[DATA_W];
      assign ovf  = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);

      always_comb begin
         res_o = sum[DATA_W-1:0];
         case (op_i)
            OP_ADDC: t_o = cout;
            OP_ADDV: t_o = ovf;
            OP_SUBC: t_o = ~cout;
            OP_SUBV: t_o = ovf;
            OP_NEGC: t_o = ~cout;
            default: t_o = t_i;
         endcase
      end
   end else begin : g_split
      logic [EXT-1:0] add1, add2, sub1, sub2, neg1, neg2;
      logic [DATA_W-1:0] addv_r, subv_r;

      assign add1   = {1'b0, a_i} + {1'b0, b_i};
      assign add2   = {1'b0, add1[DATA_W-1:0]} + EXT'(t_i);
      assign sub1   = {1'b0, a_i} - {1'b0, b_i};
      assign sub2   = {1'b0, sub1[DATA_W-1:0]} - EXT'(t_i);
      assign neg1   = {EXT{1'b0}} - {1'b0, b_i};
      assign neg2   = {1'b0, neg1[DATA_W-1:0]} - EXT'(t_i);
      assign addv_r = a_i + b_i;
      assign subv_r = a_i - b_i;

      always_comb begin
         res_o = a_i;
         t_o   = t_i;
         case (op_i)
            OP_ADDC: begin
               res_o = add2[DATA_W-1:0];
               t_o   = add1[DATA_W] | add2[DATA_W];
            end
            OP_ADDV: begin
               res_o = addv_r;
               t_o   = (a_i[MSB] == b_i[MSB]) && (addv_r[MSB] != a_i[MSB]);
            end
            OP_SUBC: begin
               res_o = sub2[DATA_W-1:0];
               t_o   = sub1[DATA_W] | sub2[DATA_W];
            end
            OP_SUBV: begin
               res_o = subv_r;
               t_o   = (a_i[MSB] != b_i[MSB]) && (subv_r[MSB] != a_i[MSB]);
            end
            OP_NEGC: begin
               res_o = neg2[DATA_W-1:0];
               t_o   = (neg1[DATA_W-1:0] != '0) | neg2[DATA_W];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/flagalu_unit.sv
module flagalu_unit
   import flagalu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [15:0]       insn_i,
   input  logic [DATA_W-1:0] rn_i,
   input  logic [DATA_W-1:0] rm_i,
   input  logic              t_i,
   output logic [DATA_W-1:0] rn_o,
   output logic              t_o,
   output logic              wr_en_o,
   output logic              done_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("flagalu_unit: DATA_W must be at least 2");
   end
   if (INSN_W != 16) begin : g_bad_insn
      $error("flagalu_unit: instruction width must be 16");
   end

   op_e               op;
   logic [DATA_W-1:0] res;
   logic              t_new, valid;

   flagalu_decode u_dec (
      .insn_i (insn_i),
      .op_o   (op)
   );

   flagalu_core #(
      .DATA_W       (DATA_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_core (
      .op_i    (op),
      .a_i     (rn_i),
      .b_i     (rm_i),
      .t_i     (t_i),
      .res_o   (res),
      .t_o     (t_new),
      .valid_o (valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rn_o    <= '0;
         t_o     <= 1'b0;
         wr_en_o <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o  <= start_i;
         wr_en_o <= start_i & valid;
         if (start_i) begin
            rn_o <= valid ? res : rn_i;
            t_o  <= t_new;
         end
      end
   end
endmodule

// File: rtl/flagalu_unit_chk.sv
module flagalu_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [15:0]       insn_i,
   input logic [DATA_W-1:0] rn_i,
   input logic [DATA_W-1:0] rm_i,
   input logic              t_i,
   input logic [DATA_W-1:0] rn_o,
   input logic              t_o,
   input logic              wr_en_o,
   input logic              done_o
);
   logic is_dual, is_negc, is_addv, known;
   assign is_dual = (insn_i[15:12] == 4'h3);
   assign is_addv = is_dual && (insn_i[3:0] == 4'hF);
   assign is_negc = (insn_i[15:12] == 4'h6) && (insn_i[3:0] == 4'hA);
   assign known   = is_negc || (is_dual && (insn_i[3:0] == 4'hE || insn_i[3:0] == 4'hF ||
                                            insn_i[3:0] == 4'hA || insn_i[3:0] == 4'hB));

   // R7: done follows start by one cycle
   a_r7_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);
   // R7: write-enable only with done
   a_r7_wr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> done_o);
   // R9: idle cycle keeps outputs and lowers strobes
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (!done_o && !wr_en_o && $stable(rn_o) && $stable(t_o)));
   // R8: unmatched word passes T and Rn through
   a_r8_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !known) |=> (!wr_en_o && t_o == $past(t_i) && rn_o == $past(rn_i)));
   // R3: overflow-add result
   a_r3_addv_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && is_addv) |=> (wr_en_o && rn_o == DATA_W'($past(rn_i) + $past(rm_i))));
   // R6: negate-with-borrow flag
   a_r6_negc_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && is_negc) |=> (t_o == (($past(rm_i) != '0) || $past(t_i))));
endmodule

bind flagalu_unit flagalu_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .insn_i  (insn_i),
   .rn_i    (rn_i),
   .rm_i    (rm_i),
   .t_i     (t_i),
   .rn_o    (rn_o),
   .t_o     (t_o),
   .wr_en_o (wr_en_o),
   .done_o  (done_o)
);

// File: tb/flagalu_unit_tb.sv
module flagalu_unit_tb_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [15:0]  insn_i = '0;
   logic [W-1:0] rn_i = '0, rm_i = '0;
   logic         t_i = 1'b0;
   logic [W-1:0] rn_o;
   logic         t_o, wr_en_o, done_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   flagalu_unit #(.DATA_W(W), .SHARED_ADDER(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
      .rn_i(rn_i), .rm_i(rm_i), .t_i(t_i),
      .rn_o(rn_o), .t_o(t_o), .wr_en_o(wr_en_o), .done_o(done_o)
   );

   // expected {wr, t, result}
   function automatic logic [W+1:0] model(input logic [15:0] insn, input logic [W-1:0] rn,
                                          input logic [W-1:0] rm, input logic t);
      logic [63:0] x, y;
      logic [W-1:0] r;
      logic nt;
      logic [3:0] hi, lo;
      hi = insn[15:12]; lo = insn[3:0];
      if (hi == 4'h3 && lo == 4'hE) begin          // R2
         x = 64'(rn) + 64'(rm);
         y = 64'(x[W-1:0]) + 64'(t);
         return {1'b1, x[W] | y[W], y[W-1:0]};
      end else if (hi == 4'h3 && lo == 4'hF) begin // R3
         r = rn + rm;
         nt = (rn[W-1] == rm[W-1]) && (r[W-1] != rn[W-1]);
         return {1'b1, nt, r};
      end else if (hi == 4'h3 && lo == 4'hA) begin // R4
         nt = (rm > rn);
         r = rn - rm;
         nt = nt | (32'(t) > r);
         return {1'b1, nt, r - W'(t)};
      end else if (hi == 4'h3 && lo == 4'hB) begin // R5
         r = rn - rm;
         nt = (rn[W-1] != rm[W-1]) && (r[W-1] != rn[W-1]);
         return {1'b1, nt, r};
      end else if (hi == 4'h6 && lo == 4'hA) begin // R6
         r = W'(0) - rm;
         nt = (r != '0) || (32'(t) > r);
         return {1'b1, nt, r - W'(t)};
      end
      return {1'b0, t, rn};                        // R8
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at negedge, result is visible at the following negedge
   task automatic run_op(input string tag, input logic [15:0] insn, input logic [W-1:0] rn,
                         input logic [W-1:0] rm, input logic t);
      logic [W+1:0] e;
      e = model(insn, rn, rm, t);
      insn_i = insn; rn_i = rn; rm_i = rm; t_i = t; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check({tag, " result"}, 64'(rn_o), 64'(e[W-1:0]));
      check({tag, " T"}, 64'(t_o), 64'(e[W]));
      check({tag, " wr_en/done"}, {62'd0, wr_en_o, done_o}, {62'd0, e[W+1], 1'b1});
   endtask

   initial begin
      logic [W-1:0] keep_r;
      logic keep_t;
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      check("R10 reset outputs", {30'd0, wr_en_o, done_o, rn_o}, 64'd0);
      check("R10 reset T", 64'(t_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 idle after reset", {62'd0, wr_en_o, done_o}, 64'd0);

      // directed corners
      run_op("R2 addc wrap", 16'h312E, 32'hFFFF_FFFF, 32'h0, 1'b1);
      run_op("R2 addc first carry", 16'h3A5E, 32'h8000_0000, 32'h8000_0000, 1'b0);
      run_op("R3 addv pos ovf", 16'h301F, 32'h7FFF_FFFF, 32'h1, 1'b0);
      run_op("R3 addv no ovf", 16'h301F, 32'hFFFF_FFFF, 32'h1, 1'b1);
      run_op("R4 subc borrow by T", 16'h300A, 32'h0, 32'h0, 1'b1);
      run_op("R4 subc no borrow", 16'h3FFA, 32'h5, 32'h3, 1'b1);
      run_op("R5 subv ovf", 16'h344B, 32'h8000_0000, 32'h1, 1'b0);
      run_op("R5 subv no ovf", 16'h344B, 32'h1, 32'h1, 1'b1);
      run_op("R6 negc zero T0", 16'h612A, 32'h0, 32'h0, 1'b0);
      run_op("R6 negc zero T1", 16'h612A, 32'h0, 32'h0, 1'b1);
      run_op("R6 negc nonzero", 16'h6BCA, 32'h1234, 32'h1, 1'b0);
      run_op("R8 unmatched 300C", 16'h300C, 32'hDEAD_BEEF, 32'h1, 1'b1);
      run_op("R8 unmatched 600E", 16'h600E, 32'h1111_2222, 32'h5, 1'b0);

      // R7 done is a single-cycle pulse; R9 outputs hold while idle
      keep_r = rn_o; keep_t = t_o;
      @(negedge clk);
      check("R7 done single pulse", {62'd0, wr_en_o, done_o}, 64'd0);
      rn_i = 32'hA5A5_A5A5; rm_i = 32'h5A5A_5A5A; t_i = ~keep_t; insn_i = 16'h300E;
      @(negedge clk);
      check("R9 hold result", 64'(rn_o), 64'(keep_r));
      check("R9 hold T", 64'(t_o), 64'(keep_t));

      // R1 middle bits do not alter outcome
      for (int i = 0; i < 8; i++) begin
         logic [W-1:0] a, b;
         logic [7:0] mid;
         a = $urandom(); b = $urandom(); mid = 8'($urandom());
         run_op("R1 middle bits subc", {4'h3, mid, 4'hA}, a, b, 1'b1);
      end

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         logic [15:0] w;
         logic [W-1:0] a, b;
         int k;
         k = $urandom_range(0, 6);
         w = 16'($urandom());
         case (k)
            0: w = {4'h3, w[11:4], 4'hE};
            1: w = {4'h3, w[11:4], 4'hF};
            2: w = {4'h3, w[11:4], 4'hA};
            3: w = {4'h3, w[11:4], 4'hB};
            4: w = {4'h6, w[11:4], 4'hA};
            default: ;
         endcase
         a = $urandom(); b = $urandom();
         if ($urandom_range(0, 3) == 0) a = {a[W-1], {(W-1){~a[W-1]}}};
         if ($urandom_range(0, 3) == 0) b = (b[0]) ? '0 : {W{1'b1}};
         run_op("R2 R3 R4 R5 R6 R7 R8 random", w, a, b, 1'($urandom()));
         if ($urandom_range(0, 4) == 0) @(negedge clk);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule